// File: doc/BRIEF.md
# Serial IRQ host controller

This block is the host end of the single-wire serialized interrupt channel that runs next to an LPC bus. The wire is open-drain and shared with the peripherals. The host pulls it low to open a cycle with a start frame. It then lets every peripheral signal one interrupt level in its own time slot, and closes the cycle with a stop frame. The length of the stop frame tells the peripherals which mode the next cycle uses.

Each slot is three clocks long: a sample clock, a recovery clock and a turnaround clock. The host reads the wire on the sample clock, and a low level means that slot's interrupt is asserted. Slots 0 to 15 become parallel interrupt levels. Slot 2 is routed to the SMI request output instead of to IRQ2. Configuration inputs, driven by a control register elsewhere, select:
- enable;
- continuous or quiet operation;
- the number of slots per cycle;
- the length of the start pulse;
- an output polarity for each of IRQ0, IRQ1 and SMI.

In quiet operation the wire rests released between cycles. A new cycle then begins in one of two ways: the host starts one on a `host_kick` pulse, or a peripheral pulls the wire low for one clock and the host completes the start pulse.

Top module: `sirq_host`

## Requirements
- R1: While `cfg_en` is 0 the host never drives the wire (`line_oe` = 0). Every decoded level reads inactive: `irq_o` = {14'b0, `cfg_pol_irq1`, `cfg_pol_irq0`} and `smi_o` = `cfg_pol_smi`. Stored levels are cleared.
- R2: During and after reset, with all configuration inputs at 0, `line_oe` is 0 and `irq_o` and `smi_o` are all 0.
- R3: A host-started start frame holds the wire low for 4, 6 or 8 clocks when `cfg_width` is 00, 01 or 10. The value 11 gives 4 clocks.
- R4: After the start frame the wire is released for one recovery clock. Then follow exactly 3×(17+`cfg_nframes`) clocks of data slots, during which the host does not drive the wire. The stop frame begins on the very next clock.
- R5: In each slot the wire level on the slot's first clock is sampled, and low means asserted. Slot k (k = 0..15, k ≠ 2) sets level k.
- R6: Slot 2 drives `smi_o`, and `irq_o[2]` stays at 0. Slots 16 to 31 are clocked through but change no output.
- R7: `irq_o[0]`, `irq_o[1]` and `smi_o` equal their level XOR `cfg_pol_irq0`, `cfg_pol_irq1` and `cfg_pol_smi` respectively (0 = active high, 1 = active low). The other `irq_o` bits are active high.
- R8: The stop frame is 3 clocks low in continuous mode and 2 clocks low in quiet mode, followed by one released clock. In continuous mode the next start frame begins right after that single released clock.
- R9: In quiet mode, once enabled, the host leaves the wire released until `host_kick` is high at a clock edge or a peripheral pulls the wire low.
- R10: In quiet mode, when a peripheral holds the wire low for one clock from idle, the host keeps it low so that the total start pulse equals the configured width.
- R11: Decoded levels hold their last sampled value between cycles and change only when their slot is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one wire clock per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enables all serial interrupt activity |
| cfg_quiet | input | 1 | 0 continuous, 1 quiet |
| cfg_nframes | input | 4 | Slot count minus 17 |
| cfg_width | input | 2 | Start pulse select: 00=4, 01=6, 10=8, 11=4 clocks |
| cfg_pol_irq0 | input | 1 | IRQ0 output polarity, 1 = active low |
| cfg_pol_irq1 | input | 1 | IRQ1 output polarity, 1 = active low |
| cfg_pol_smi | input | 1 | SMI output polarity, 1 = active low |
| host_kick | input | 1 | Quiet mode: start a host cycle |
| line_in | input | 1 | Sampled level of the shared wire |
| line_oe | output | 1 | 1 = host pulls the wire low |
| irq_o | output | 16 | Decoded interrupt levels, bit 2 unused |
| smi_o | output | 1 | SMI request from slot 2 |

## Verification
The hardest situation to reach from the ports is a peripheral-started cycle. The wire must be pulled low on an idle clock in quiet mode. That only happens after the host has closed a cycle with the short stop frame and then sat idle. The bench plays the peripheral side of the wire. It first sets up quiet mode and runs a kicked cycle. It then checks that the wire stays released, and finally pulls the wire low for one clock, measuring the total low time against the configured width. The sweep also covers every pulse-width code and three slot counts. In each one the bench places peripheral drives by counting clocks from the end of the start frame, so a wrong slot count appears as a misplaced stop frame.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int unsigned BASE_FRAMES = 17;
  localparam int unsigned CNT_W = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_SREC,
    S_DATA,
    S_STOP,
    S_STA
  } sirq_state_e;

  function automatic logic [CNT_W-1:0] start_len(input logic [1:0] sel);
    case (sel)
      2'b01:   start_len = CNT_W'(6);
      2'b10:   start_len = CNT_W'(8);
      default: start_len = CNT_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/sirq_seq.sv
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int unsigned NF_W   = 4,
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              quiet,
  input  logic [NF_W-1:0]   nframes,
  input  logic [1:0]        width_sel,
  input  logic              kick,
  input  logic              line_in,
  output logic              line_oe,
  output logic              samp_vld,
  output logic [SLOT_W-1:0] samp_slot,
  output logic              samp_low
);
  sirq_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [1:0]       ph_q, ph_d;
  logic [SLOT_W-1:0] last_slot;
  logic [CNT_W-1:0] wlen;

  assign last_slot = SLOT_W'(BASE_FRAMES - 1) + SLOT_W'(nframes);
  assign wlen      = start_len(width_sel);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    slot_d  = slot_q;
    ph_d    = ph_q;
    case (state_q)
      S_IDLE: begin
        if (en && (!quiet || kick)) begin
          state_d = S_START;
          cnt_d   = wlen - CNT_W'(1);
        end else if (en && !line_in) begin
          // peripheral already held the wire one clock
          state_d = S_START;
          cnt_d   = wlen - CNT_W'(2);
        end
      end
      S_START: begin
        if (cnt_q == '0) state_d = S_SREC;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      S_SREC: begin
        state_d = S_DATA;
        slot_d  = '0;
        ph_d    = 2'd0;
      end
      S_DATA: begin
        if (ph_q == 2'd2) begin
          ph_d = 2'd0;
          if (slot_q == last_slot) begin
            state_d = S_STOP;
            cnt_d   = quiet ? CNT_W'(1) : CNT_W'(2);
          end else begin
            slot_d = slot_q + SLOT_W'(1);
          end
        end else begin
          ph_d = ph_q + 2'd1;
        end
      end
      S_STOP: begin
        if (cnt_q == '0) state_d = S_STA;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      S_STA: begin
        if (en && !quiet) begin
          state_d = S_START;
          cnt_d   = wlen - CNT_W'(1);
        end else begin
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (!en) state_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
      ph_q    <= 2'd0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      slot_q  <= slot_d;
      ph_q    <= ph_d;
    end
  end

  assign line_oe   = (state_q == S_START) || (state_q == S_STOP);
  assign samp_vld  = (state_q == S_DATA) && (ph_q == 2'd0);
  assign samp_slot = slot_q;
  assign samp_low  = !line_in;

  a_r1_release_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !line_oe);
  a_r3_start_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_START) |-> (cnt_q <= CNT_W'(7)));
  a_r4_slot_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DATA) |-> (slot_q <= last_slot));
  a_r8_stop_to_ta: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == S_STOP && cnt_q == '0) |=> (state_q == S_STA && !line_oe));
  a_r9_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (en && quiet && !kick && line_in && state_q == S_IDLE) |=> !line_oe);
endmodule

// File: rtl/sirq_lvl.sv
module sirq_lvl #(
  parameter int unsigned NSLOT  = 16,
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              samp_vld,
  input  logic [SLOT_W-1:0] samp_slot,
  input  logic              samp_low,
  output logic [NSLOT-1:0]  lvl
);
  logic [NSLOT-1:0] lvl_q, lvl_d;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    always_comb begin
      if (!en)                                          lvl_d[k] = 1'b0;
      else if (samp_vld && samp_slot == SLOT_W'(k))     lvl_d[k] = samp_low;
      else                                              lvl_d[k] = lvl_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign lvl = lvl_q;

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !samp_vld) |=> $stable(lvl_q));
  a_r6_high_slot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (en && samp_vld && samp_slot >= SLOT_W'(NSLOT)) |=> $stable(lvl_q));
endmodule

// File: rtl/sirq_host.sv
module sirq_host #(
  parameter int unsigned NF_W   = 4,
  parameter int unsigned NSLOT  = 16,
  parameter int unsigned SMI_SLOT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_quiet,
  input  logic [NF_W-1:0]  cfg_nframes,
  input  logic [1:0]       cfg_width,
  input  logic             cfg_pol_irq0,
  input  logic             cfg_pol_irq1,
  input  logic             cfg_pol_smi,
  input  logic             host_kick,
  input  logic             line_in,
  output logic             line_oe,
  output logic [NSLOT-1:0] irq_o,
  output logic             smi_o
);
  localparam int unsigned SLOT_W = $clog2(17 + (1 << NF_W));

  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic              samp_vld, samp_low;
  logic [SLOT_W-1:0] samp_slot;
  logic [NSLOT-1:0]  lvl, lvl_g;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  sirq_seq #(.NF_W(NF_W), .SLOT_W(SLOT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (cfg_en),
    .quiet     (cfg_quiet),
    .nframes   (cfg_nframes),
    .width_sel (cfg_width),
    .kick      (host_kick),
    .line_in   (line_in),
    .line_oe   (line_oe),
    .samp_vld  (samp_vld),
    .samp_slot (samp_slot),
    .samp_low  (samp_low)
  );

  sirq_lvl #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_lvl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (cfg_en),
    .samp_vld  (samp_vld),
    .samp_slot (samp_slot),
    .samp_low  (samp_low),
    .lvl       (lvl)
  );

  assign lvl_g = cfg_en ? lvl : '0;

  always_comb begin
    irq_o           = lvl_g;
    irq_o[SMI_SLOT] = 1'b0;
    irq_o[0]        = lvl_g[0] ^ cfg_pol_irq0;
    irq_o[1]        = lvl_g[1] ^ cfg_pol_irq1;
  end
  assign smi_o = lvl_g[SMI_SLOT] ^ cfg_pol_smi;

  a_r7_smi_idle_level: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_en |-> (smi_o == cfg_pol_smi));
endmodule

// File: tb/sim_sirq_host.sv
`timescale 1ns/1ps
module sim_sirq_host;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en, cfg_quiet, cfg_pol_irq0, cfg_pol_irq1, cfg_pol_smi, host_kick;
  logic [3:0]  cfg_nframes;
  logic [1:0]  cfg_width;
  logic        dev_low;
  logic        line_oe, smi_o;
  logic [15:0] irq_o;
  wire         line = ~(line_oe | dev_low);

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sirq_host u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_quiet(cfg_quiet),
    .cfg_nframes(cfg_nframes), .cfg_width(cfg_width),
    .cfg_pol_irq0(cfg_pol_irq0), .cfg_pol_irq1(cfg_pol_irq1), .cfg_pol_smi(cfg_pol_smi),
    .host_kick(host_kick), .line_in(line), .line_oe(line_oe),
    .irq_o(irq_o), .smi_o(smi_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wid(input logic [1:0] s);
    return (s == 2'b01) ? 6 : (s == 2'b10) ? 8 : 4;
  endfunction

  // {smi, irq[15:0]} from a slot pattern (bit k = 1: slot k pulled low)
  function automatic logic [16:0] expect_out(input logic [31:0] pat, input logic [2:0] pol);
    logic [15:0] q;
    q    = pat[15:0];
    q[2] = 1'b0;
    q[0] = q[0] ^ pol[0];
    q[1] = q[1] ^ pol[1];
    return {pat[2] ^ pol[2], q};
  endfunction

  function automatic logic [2:0] pols();
    return {cfg_pol_smi, cfg_pol_irq1, cfg_pol_irq0};
  endfunction

  // plays one full cycle as the peripheral side; ends on the released clock after stop
  task automatic do_cycle(input int w_exp, input int f_exp, input int stop_exp,
                          input logic [31:0] pat, input bit pstart);
    int n;
    int bad;
    if (pstart) begin
      dev_low = 1'b1;
      #1;
    end
    n = 0;
    while (line !== 1'b0 && n < 300) begin @(negedge clk); n++; end
    n = 0;
    while (line === 1'b0 && n < 40) begin
      n++;
      @(negedge clk);
      if (pstart && n == 1) dev_low = 1'b0;
    end
    if (pstart) chk("R10 peripheral-started pulse", n, w_exp);
    else        chk("R3 start pulse width", n, w_exp);
    bad = 0;
    for (int s = 0; s < f_exp; s++) begin
      @(negedge clk);
      dev_low = pat[s % 32];
      @(negedge clk);
      dev_low = 1'b0;
      @(negedge clk);
      if (line !== 1'b1) bad++;
    end
    chk("R4 host silent in data slots", bad, 0);
    @(negedge clk);
    n = 0;
    while (line === 1'b0 && n < 40) begin n++; @(negedge clk); end
    chk("R8/R4 stop frame length at expected clock", n, stop_exp);
    chk("R5/R6/R7 decoded outputs", {smi_o, irq_o}, expect_out(pat, pols()));
  endtask

  initial begin
    int tries;
    tries = 0;
    while (!done && tries < 150000) begin @(posedge clk); tries++; end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired (R1..all)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] p1, p2;
    logic [16:0] held;
    int n, idx;
    rst_n = 1'b0; cfg_en = 0; cfg_quiet = 0; cfg_nframes = 0; cfg_width = 0;
    cfg_pol_irq0 = 0; cfg_pol_irq1 = 0; cfg_pol_smi = 0; host_kick = 0; dev_low = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset line released", line_oe, 0);
    chk("R2 reset outputs", {smi_o, irq_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 after reset, disabled", {line_oe, smi_o, irq_o}, 0);

    // continuous sweep over width code and slot count
    idx = 0;
    for (int w = 0; w < 4; w++) begin
      for (int ns = 0; ns < 3; ns++) begin
        cfg_en = 0;
        @(negedge clk);
        cfg_width = 2'(w);
        cfg_nframes = (ns == 0) ? 4'd0 : (ns == 1) ? 4'd7 : 4'd15;
        cfg_quiet = 0;
        {cfg_pol_smi, cfg_pol_irq1, cfg_pol_irq0} = 3'(idx);
        n = 0;
        repeat (4) begin @(negedge clk); if (line !== 1'b1) n++; end
        chk("R1 no drive while disabled", n, 0);
        chk("R1 inactive outputs", {smi_o, irq_o}, {cfg_pol_smi, 14'b0, cfg_pol_irq1, cfg_pol_irq0});
        p1 = (32'h9E3779B9 * 32'(idx + 1)) ^ 32'(idx << 3);
        p2 = ~p1 ^ 32'h0F0F_3C3C;
        cfg_en = 1;
        do_cycle(wid(2'(w)), 17 + int'(cfg_nframes), 3, p1, 0);
        n = 0;
        while (line === 1'b1 && n < 20) begin n++; @(negedge clk); end
        chk("R8 one released clock then restart", n, 1);
        do_cycle(wid(2'(w)), 17 + int'(cfg_nframes), 3, p2, 0);
        chk("R11 second cycle replaced levels", {smi_o, irq_o}, expect_out(p2, pols()));
        idx++;
      end
    end

    // quiet mode: kicked cycle, idle hold, then peripheral-started cycle
    for (int q = 0; q < 2; q++) begin
      cfg_en = 0;
      @(negedge clk);
      cfg_width = (q == 0) ? 2'b01 : 2'b10;
      cfg_nframes = (q == 0) ? 4'd3 : 4'd15;
      cfg_quiet = 1;
      {cfg_pol_smi, cfg_pol_irq1, cfg_pol_irq0} = (q == 0) ? 3'b101 : 3'b010;
      repeat (2) @(negedge clk);
      cfg_en = 1;
      n = 0;
      repeat (6) begin @(negedge clk); if (line !== 1'b1) n++; end
      chk("R9 quiet idle before kick", n, 0);
      host_kick = 1;
      @(negedge clk);
      host_kick = 0;
      p1 = 32'h5A5A_0007 + 32'(q * 32'h1234);
      do_cycle(wid(cfg_width), 17 + int'(cfg_nframes), 2, p1, 0);
      held = {smi_o, irq_o};
      n = 0;
      repeat (10) begin @(negedge clk); if (line !== 1'b1) n++; end
      chk("R9 quiet idle after stop", n, 0);
      chk("R11 levels held while idle", {smi_o, irq_o}, held);
      p2 = 32'hC3A0_FFF8 ^ 32'(q);
      do_cycle(wid(cfg_width), 17 + int'(cfg_nframes), 2, p2, 1);
      chk("R10 outputs after peripheral cycle", {smi_o, irq_o}, expect_out(p2, pols()));
    end

    cfg_en = 0;
    repeat (3) @(negedge clk);
    chk("R1 disabled at end", {line_oe, smi_o, irq_o},
        {1'b0, cfg_pol_smi, 14'b0, cfg_pol_irq1, cfg_pol_irq0});
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule